// File: doc/BRIEF.md
# Timing-Speculative Error-Detecting Register Bank

This block is a pipeline register bank that checks its own capture timing. Every data bit is held twice. A main register takes the input on the rising clock edge. A shadow register takes the same input again on a separate strobe input, which rises a fixed fraction of the cycle later (about 20%, and never more than half a cycle). When a bit settles after the clock edge but before the strobe, the two copies disagree. An XOR compare then flags the register group that holds that bit.

The bits are split into G groups of N bits each. Group g holds bits `[g*N +: N]`. Each group raises its own error, and the global error is the OR of all group errors. When a mismatch is seen, the main register is reloaded from the shadow copy on the next clock edge, so the downstream stage receives the corrected word one cycle late. During that repair the block withholds the faulty word from the output and stalls its input.

The input side is a valid/ready stream:
- A word transfers on a rising clock edge when `in_valid` and `in_ready` are both high.
- `in_ready` drops only in a cycle whose captured word has failed the compare. An upstream stage that sees it low must hold its word until the next edge.
- The output side has no back-pressure. `out_valid` marks a word the next stage must take in that cycle.

The strobe is an ordinary input, so the design stays synthesizable. Delay tuning and min-path buffering are left to the physical design.

Top module: `tspec_reg_bank`

## Requirements
- R1: While `rst_n` is low, both copies of every bit and all flags are cleared. After reset, `out_valid`, `out_data`, `grp_err` and `any_err` are 0 and `in_ready` is 1.
- R2: A word presented with `in_valid` high while `in_ready` is high is captured at the clock edge. After the strobe it appears on `out_data` with `out_valid` high.
- R3: If the input is already stable at the clock edge and stays stable through the strobe, no group error is raised. This holds even when the input changed just before the edge.
- R4: If the input bits of a group change between the clock edge and the strobe of a cycle that captured a word, that group's `grp_err` bit is high for exactly the one cycle after the next clock edge.
- R5: `any_err` is the OR of all `grp_err` bits.
- R6: In a cycle whose captured word fails the compare, `out_valid` is low once the strobe has passed. At the next edge, `out_data` takes the value sampled at the strobe and `out_valid` is high.
- R7: In a cycle whose captured word fails the compare, `in_ready` is low, so no word is accepted at the next edge. In the repair cycle that follows, `in_ready` is high and no compare is made.
- R8: If `in_valid` is low at an edge, `out_valid` is low for that cycle, `out_data` holds its value, and a late input change raises no error.
- R9: Errors are kept per group. A late change confined to the bits of group g sets only bit g of `grp_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main capture clock, rising edge |
| strobe | input | 1 | Delayed sampling strobe; its rising edge falls within the first half of each clock cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block accepts a word at the next edge |
| in_data | input | N*G | Input word; group g in bits [g*N +: N] |
| out_valid | output | 1 | `out_data` holds a checked word |
| out_data | output | N*G | Main register contents |
| grp_err | output | G | Registered per-group timing error |
| any_err | output | 1 | OR of all group errors |

## Verification
The input is driven in four patterns.
- Changing the word only before the clock edge separates a clean capture from a false alarm.
- Changing one group's bits between the edge and the strobe shows that the error stays in that group and that the repair loads the late value.
- Making the same late change while `in_valid` is low shows that an idle cycle is never checked.
- Back-to-back late changes across all groups, mixed with random traffic and the stall that follows each error, show that the repair cycle is neither compared nor allowed to accept new data.

// File: rtl/tspec_pkg.sv
package tspec_pkg;
  localparam int unsigned TSPEC_GRP_BITS_DEF = 8;
  localparam int unsigned TSPEC_GRP_CNT_DEF  = 4;
endpackage

// File: rtl/tspec_err_merge.sv
module tspec_err_merge #(
  parameter int unsigned G = 4
) (
  input  logic [G-1:0] flags,
  output logic         merged
);
  logic [G:0] chain;
  assign chain[0] = 1'b0;
  for (genvar gi = 0; gi < G; gi++) begin : g_or
    assign chain[gi+1] = chain[gi] | flags[gi];
  end
  assign merged = chain[G];
endmodule

// File: rtl/tspec_group.sv
module tspec_group #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         strobe,
  input  logic         rst_n,
  input  logic         load,
  input  logic         fix,
  input  logic         chk_en,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic         mism,
  output logic         err_q
);
  logic [N-1:0] main_q;
  logic [N-1:0] shadow_q;
  logic [N-1:0] diff;

  // main copy: edge capture, or repair from the shadow copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    main_q <= '0;
    else if (fix)  main_q <= shadow_q;
    else if (load) main_q <= d;
  end

  // late copy on the delayed strobe
  always_ff @(posedge strobe or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= d;
  end

  for (genvar bi = 0; bi < N; bi++) begin : g_cmp
    assign diff[bi] = main_q[bi] ^ shadow_q[bi];
  end

  assign mism = chk_en & (|diff);
  assign q    = main_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= mism;
  end

  AST_FIX_FROM_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    fix |=> (q == $past(shadow_q))); // R6
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fix && !load) |=> $stable(q)); // R8
endmodule

// File: rtl/tspec_reg_bank.sv
module tspec_reg_bank
  import tspec_pkg::*;
#(
  parameter int unsigned N = TSPEC_GRP_BITS_DEF,
  parameter int unsigned G = TSPEC_GRP_CNT_DEF,
  localparam int unsigned W = N * G
) (
  input  logic         clk,
  input  logic         strobe,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic [G-1:0] grp_err,
  output logic         any_err
);
  logic         cap_q;
  logic         recov_q;
  logic         load;
  logic         chk_en;
  logic         mism_any;
  logic [G-1:0] mism_vec;

  assign load   = in_valid & in_ready;
  assign chk_en = cap_q & ~recov_q;

  for (genvar gi = 0; gi < G; gi++) begin : g_grp
    tspec_group #(.N(N)) u_grp (
      .clk    (clk),
      .strobe (strobe),
      .rst_n  (rst_n),
      .load   (load),
      .fix    (mism_any),
      .chk_en (chk_en),
      .d      (in_data[gi*N +: N]),
      .q      (out_data[gi*N +: N]),
      .mism   (mism_vec[gi]),
      .err_q  (grp_err[gi])
    );
  end

  tspec_err_merge #(.G(G)) u_mism_or (.flags(mism_vec), .merged(mism_any));
  tspec_err_merge #(.G(G)) u_err_or  (.flags(grp_err),  .merged(any_err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      recov_q <= 1'b0;
    end else begin
      recov_q <= mism_any;
      cap_q   <= mism_any | load;
    end
  end

  assign in_ready  = ~mism_any;
  assign out_valid = cap_q & ~mism_any;

  AST_READY_IN_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    recov_q |-> in_ready); // R7
  AST_SINGLE_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    recov_q |=> !recov_q); // R7
  AST_ERR_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> (grp_err == '0)); // R4
  AST_ERR_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_err) |-> $past(!in_ready)); // R5
endmodule

// File: tb/tspec_reg_bank_tb.sv
`timescale 1ns/1ps
module tspec_reg_bank_tb;
  localparam int N = 8;
  localparam int G = 4;
  localparam int W = N * G;

  logic clk = 1'b0, strobe = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, any_err;
  logic [W-1:0] out_data;
  logic [G-1:0] grp_err;

  int n_chk = 0, n_bad = 0;

  logic [W-1:0] m_main, m_shadow;
  logic m_cap, m_recov;
  logic [G-1:0] m_err, m_mism;

  tspec_reg_bank #(.N(N), .G(G)) u_dut (
    .clk(clk), .strobe(strobe), .rst_n(rst_n), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .grp_err(grp_err), .any_err(any_err));

  always #5 clk = ~clk;
  always begin
    @(posedge clk);
    #2 strobe = 1'b1;
    #5 strobe = 1'b0;
  end

  function automatic logic [G-1:0] grp_diff(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [G-1:0] r;
    for (int g = 0; g < G; g++) r[g] = (a[g*N +: N] != b[g*N +: N]);
    return r;
  endfunction

  function automatic logic [W-1:0] grp_mask(input int g);
    logic [W-1:0] m = '0;
    m[g*N +: N] = '1;
    return m;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock cycle: de before the edge, ds from 1 ns after the edge
  task automatic step(input logic v, input logic [W-1:0] de,
                      input logic [W-1:0] ds, input string etag);
    in_valid = v;
    in_data  = de;
    if (|m_mism) begin
      m_main  = m_shadow;
      m_cap   = 1'b1;
      m_recov = 1'b1;
    end else begin
      m_recov = 1'b0;
      if (v) begin m_main = de; m_cap = 1'b1; end
      else m_cap = 1'b0;
    end
    m_err = m_mism;
    @(posedge clk);
    #1 in_data = ds;
    #4;
    m_shadow = ds;
    m_mism   = (m_cap && !m_recov) ? grp_diff(m_main, m_shadow) : '0;
    check(m_recov ? "R6" : "R2", "out_data", out_data, m_main);
    check(v ? "R6" : "R8", "out_valid", W'(out_valid), W'(m_cap && !(|m_mism)));
    check("R7", "in_ready", W'(in_ready), W'(!(|m_mism)));
    check(etag, "grp_err", W'(grp_err), W'(m_err));
    check("R5", "any_err", W'(any_err), W'(|m_err));
    #1;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] a, d;
    void'($urandom(32'd20240611));
    m_main = '0; m_shadow = '0; m_cap = 1'b0; m_recov = 1'b0;
    m_err = '0; m_mism = '0;
    in_data = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    #6;
    // R1 reset state
    check("R1", "out_valid", W'(out_valid), '0);
    check("R1", "out_data", out_data, '0);
    check("R1", "grp_err", W'(grp_err), '0);
    check("R1", "any_err", W'(any_err), '0);
    check("R1", "in_ready", W'(in_ready), W'(1));
    rst_n = 1'b1;

    // R3: clean capture, then a change only before the edge
    step(1'b1, 32'h1234_5678, 32'h1234_5678, "R3");
    step(1'b1, 32'hA5A5_0F0F, 32'hA5A5_0F0F, "R3");
    // R9: late change confined to group 2
    a = 32'h0101_0101;
    step(1'b1, a, a ^ grp_mask(2), "R9");
    d = a ^ grp_mask(2);
    step(1'b1, d, d, "R9");   // repair cycle, expect grp_err = 4'b0100
    step(1'b1, d, d, "R4");
    // R8: late toggle while idle
    step(1'b0, 32'hCAFE_0000, 32'hCAFE_FFFF, "R8");
    step(1'b0, 32'hCAFE_FFFF, 32'hCAFE_FFFF, "R8");
    // R4: late change in every group
    step(1'b1, 32'h0000_0000, 32'hFFFF_FFFF, "R4");
    step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
    step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");

    for (int i = 0; i < 600; i++) begin
      logic v;
      logic [W-1:0] de, ds;
      if (|m_mism) begin
        v = 1'b1; de = in_data; ds = de;
      end else begin
        v  = ($urandom % 4) != 0;
        de = $urandom;
        ds = de;
        if (($urandom % 4) == 0) ds = de ^ ($urandom & grp_mask($urandom % G));
        if (($urandom % 8) == 0) ds = de ^ W'($urandom);
      end
      step(v, de, ds, (ds == de) ? "R3" : "R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule